// File: doc/BRIEF.md
# I2C Bus Clock Phase Generator

This block derives the serial clock timing of an I2C master from the module clock. It divides in two stages. A power-of-two prescaler makes an intermediate tick at f0 = fclk / 2^N. A second counter divides f0 by (M+1) to make a phase strobe. Each SCL period is ten phase steps long, so fbus = f0 / (10 × (M+1)). For example, with f0 at 12 MHz, M = 11 gives a 100 kHz bus and M = 2 gives a 400 kHz bus.

The two divider fields share one 8-bit configuration register, and the register reads back what was written. A new setting is held in a shadow copy and only reaches the dividers at the SCL period boundary, so a bit never changes speed halfway through. The phase sequencer drives SCL low for phases 0 to 4 and releases it for phases 5 to 9. It marks the SDA change point (phase 2) and the SDA sample point (phase 7) with one-cycle pulses, which the bit engine uses.

During the high half, a slave may hold SCL low. When the line is read back low in that half, the sequencer holds its phase until the line is seen high again.

Top module: `i2c_sclgen`

## Requirements
- R1: While reset is held, the phase is 0, `scl_out` is 0, `cfg_rdata` is 0x00, and `phase_tick`, `sda_change` and `sda_sample` are all 0.
- R2: A write with `cfg_we` high stores N from `cfg_wdata[2:0]` and M from `cfg_wdata[6:3]`. From the cycle after the write, `cfg_rdata` returns that value with bit 7 reading 0. Bit 7 of a write has no effect on timing.
- R3: When no slave stretches the clock, every phase lasts exactly 2^N × (M+1) module clocks, and one SCL period (from one falling edge of `scl_out` to the next) lasts 10 × 2^N × (M+1) clocks. This holds for every N in 0..7 and every M in 0..15.
- R4: `scl_out` is 0 during phases 0–4 and 1 during phases 5–9. In an unstretched period it is high for exactly half the period.
- R5: `phase_tick` is a one-cycle pulse in the first cycle of each new phase. There are exactly ten pulses per unstretched SCL period, and the phase changes in no other cycle.
- R6: `sda_change` pulses for one cycle in the first cycle of phase 2, which is 2 phase lengths after the falling edge of SCL. `sda_sample` pulses for one cycle in the first cycle of phase 7, which is 7 phase lengths after the falling edge.
- R7: A configuration write takes effect only at the next step from phase 9 to phase 0. The SCL period in progress finishes with the old setting, and the period that starts at that boundary uses the new one.
- R8: When `scl_in` is 0 while the phase is in 5–9, the phase does not advance. It advances on the first phase strobe after `scl_in` is seen 1. With N = 0 and M = 0, holding `scl_in` low for S clocks from the rising edge makes the high time 5 + S clocks.
- R9: When `scl_in` is 0 during phases 0–4, the low half still lasts 5 phase lengths.
- R10: The phase stays in the range 0–9, counts up by one, and steps from 9 back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 8 | Write data: N in bits 2:0, M in bits 6:3, bit 7 unused |
| cfg_rdata | output | 8 | Stored configuration value, with bit 7 reading 0 |
| scl_in | input | 1 | SCL line level as read back, already synchronous to `clk` |
| scl_out | output | 1 | SCL drive level: 0 drives the line low, 1 releases it |
| phase | output | 4 | Current phase, 0 to 9 |
| phase_tick | output | 1 | Pulse in the first cycle of each phase |
| sda_change | output | 1 | Pulse in the first cycle of phase 2 |
| sda_sample | output | 1 | Pulse in the first cycle of phase 7 |

## Verification
The properties assume that `scl_in` is synchronous to `clk`. They also assume it can be low while `scl_out` is released only when a slave is really holding the line. The bench therefore derives `scl_in` from `scl_out` ANDed with its own stretch flag, and it changes that flag and every other input only on falling clock edges. Stretch windows are placed by watching the SCL edges at the ports, so the line is held low only while the high or low half the test targets is in progress. Only the N = 0, M = 0 setting is used for stretching, so the resulting high time is exact rather than rounded to a phase length.

// File: rtl/i2c_sclgen_pkg.sv
// Package: shared constants and the divider-configuration type for the
// I2C SCL phase generator. Assumes a ten-phase SCL period.
package i2c_sclgen_pkg;
    localparam int N_W        = 3;   // prescaler exponent field width
    localparam int M_W        = 4;   // linear divider field width
    localparam int CFG_W      = 8;   // register width seen by software
    localparam int PHASES     = 10;  // phase steps per SCL period
    localparam int HIGH_START = 5;   // first phase with SCL released
    localparam int SDA_CHG_PH = 2;   // SDA change point
    localparam int SDA_SMP_PH = 7;   // SDA sample point
    localparam int PH_W       = $clog2(PHASES);

    // Packed so that m lands in bits 6:3 and n in bits 2:0.
    typedef struct packed {
        logic [M_W-1:0] m;
        logic [N_W-1:0] n;
    } div_cfg_t;
endpackage

// File: rtl/i2c_sclgen_cfg.sv
// Configuration register with a shadow copy. Software writes land in the
// shadow at once; the active copy that feeds the dividers is refreshed only
// when 'apply' marks the SCL period boundary. Assumes apply is a 1-cycle strobe.
module i2c_sclgen_cfg
    import i2c_sclgen_pkg::*;
#(
    parameter div_cfg_t RESET_CFG = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             apply,
    output logic [CFG_W-1:0] rd_data,
    output div_cfg_t         act
);
    localparam int FLD_W = $bits(div_cfg_t);

    div_cfg_t shadow_q;
    div_cfg_t act_q;

    // Capture software writes; the unused top bit is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= RESET_CFG;
        end else if (wr_en) begin
            shadow_q <= wr_data[FLD_W-1:0];
        end
    end

    // Move the shadow into the dividers only at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= RESET_CFG;
        end else if (apply) begin
            act_q <= shadow_q;
        end
    end

    // Zero-extend the shadow for readback.
    always_comb begin
        rd_data            = '0;
        rd_data[FLD_W-1:0] = shadow_q;
    end

    assign act = act_q;
endmodule

// File: rtl/i2c_sclgen_prescale.sv
// Power-of-two prescaler: emits f0_tick once every 2^n_sel clocks.
// Assumes n_sel changes only when the counter is at zero (period boundary).
module i2c_sclgen_prescale #(
    parameter int NW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NW-1:0] n_sel,
    output logic          f0_tick
);
    localparam int CNT_W = (1 << NW) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // Terminal count 2^n - 1 built as a mask of n low ones.
    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            limit[i] = (i < int'(n_sel));
        end
    end

    assign f0_tick = (cnt_q == limit);

    // Free-running count that restarts on each f0 tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (f0_tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_sclgen_div.sv
// Linear (M+1) divider on the f0 tick: emits phase_strobe on every
// (m_sel+1)-th f0 tick. Assumes m_sel changes only with the counter at zero.
module i2c_sclgen_div #(
    parameter int MW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          f0_tick,
    input  logic [MW-1:0] m_sel,
    output logic          phase_strobe
);
    logic [MW-1:0] cnt_q;

    assign phase_strobe = f0_tick && (cnt_q == m_sel);

    // Count f0 ticks, wrapping after m_sel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (f0_tick) begin
            if (cnt_q == m_sel) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_sclgen_seq.sv
// Phase sequencer: steps through the SCL phases on each strobe, holds in
// the high half while the line reads low, and flags the SDA points.
// Assumes scl_in is already synchronous to clk.
module i2c_sclgen_seq
    import i2c_sclgen_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strobe,
    input  logic            scl_in,
    output logic [PH_W-1:0] phase,
    output logic            scl_out,
    output logic            tick,
    output logic            chg,
    output logic            smp,
    output logic            wrap
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);
    localparam logic [PH_W-1:0] PH_HIGH = PH_W'(HIGH_START);
    localparam logic [PH_W-1:0] PH_PCHG = PH_W'(SDA_CHG_PH - 1);
    localparam logic [PH_W-1:0] PH_PSMP = PH_W'(SDA_SMP_PH - 1);

    logic [PH_W-1:0] phase_q;
    logic            stall;
    logic            advance;
    logic            tick_q;
    logic            chg_q;
    logic            smp_q;

    // A released line that still reads low is held by a slave.
    assign stall   = (phase_q >= PH_HIGH) && !scl_in;
    assign advance = strobe && !stall;
    assign wrap    = advance && (phase_q == PH_LAST);

    // Phase counter with wrap at the last phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (advance) begin
            phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
        end
    end

    // Pulses aligned with the first cycle of the new phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= 1'b0;
            chg_q  <= 1'b0;
            smp_q  <= 1'b0;
        end else begin
            tick_q <= advance;
            chg_q  <= advance && (phase_q == PH_PCHG);
            smp_q  <= advance && (phase_q == PH_PSMP);
        end
    end

    assign phase   = phase_q;
    assign scl_out = (phase_q >= PH_HIGH);
    assign tick    = tick_q;
    assign chg     = chg_q;
    assign smp     = smp_q;
endmodule

// File: rtl/i2c_sclgen.sv
// Top of the I2C SCL phase generator: config register, 2^N prescaler,
// (M+1) divider and ten-phase sequencer. Assumes scl_in is synchronous.
module i2c_sclgen
    import i2c_sclgen_pkg::*;
#(
    parameter div_cfg_t RESET_CFG = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             scl_in,
    output logic             scl_out,
    output logic [PH_W-1:0]  phase,
    output logic             phase_tick,
    output logic             sda_change,
    output logic             sda_sample
);
    div_cfg_t cfg_act;
    logic     f0_tick;
    logic     phase_strobe;
    logic     period_wrap;

    i2c_sclgen_cfg #(.RESET_CFG(RESET_CFG)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .apply   (period_wrap),
        .rd_data (cfg_rdata),
        .act     (cfg_act)
    );

    i2c_sclgen_prescale #(.NW(N_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .n_sel   (cfg_act.n),
        .f0_tick (f0_tick)
    );

    i2c_sclgen_div #(.MW(M_W)) u_div (
        .clk          (clk),
        .rst_n        (rst_n),
        .f0_tick      (f0_tick),
        .m_sel        (cfg_act.m),
        .phase_strobe (phase_strobe)
    );

    i2c_sclgen_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (phase_strobe),
        .scl_in  (scl_in),
        .phase   (phase),
        .scl_out (scl_out),
        .tick    (phase_tick),
        .chg     (sda_change),
        .smp     (sda_sample),
        .wrap    (period_wrap)
    );
endmodule

// File: rtl/i2c_sclgen_chk.sv
// Property checker for i2c_sclgen, bound to every instance of the top.
module i2c_sclgen_chk
    import i2c_sclgen_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            scl_in,
    input logic [PH_W-1:0] phase,
    input logic            phase_tick,
    input logic            sda_change,
    input logic            sda_sample,
    input div_cfg_t        cfg_act
);
    assert_phase_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= PH_W'(PHASES - 1));

    assert_phase_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_tick && phase == '0) |-> $past(phase) == PH_W'(PHASES - 1));

    assert_tick_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
        phase_tick |-> phase != $past(phase));

    assert_no_tick_still_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_tick |-> $stable(phase));

    assert_stretch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase >= PH_W'(HIGH_START) && !scl_in) |=> $stable(phase));

    assert_sda_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sda_change |-> (phase == PH_W'(SDA_CHG_PH) && phase_tick));

    assert_sda_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sda_sample |-> (phase == PH_W'(SDA_SMP_PH) && phase_tick));

    assert_cfg_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_act) |-> (phase == '0 && phase_tick));
endmodule

bind i2c_sclgen i2c_sclgen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_in     (scl_in),
    .phase      (phase),
    .phase_tick (phase_tick),
    .sda_change (sda_change),
    .sda_sample (sda_sample),
    .cfg_act    (cfg_act)
);

// File: tb/test_i2c_sclgen.sv
// Self-checking bench for i2c_sclgen: table of configurations, then directed cases.
module test_i2c_sclgen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       hold = 1'b0;
    logic       scl_in;
    logic       scl_out;
    logic [3:0] phase;
    logic       phase_tick;
    logic       sda_change;
    logic       sda_sample;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    assign scl_in = scl_out & ~hold;

    i2c_sclgen i_i2c_sclgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .scl_in     (scl_in),
        .scl_out    (scl_out),
        .phase      (phase),
        .phase_tick (phase_tick),
        .sda_change (sda_change),
        .sda_sample (sda_sample)
    );

    // {config byte, expected SCL period in clocks}
    localparam logic [23:0] VEC [0:7] = '{
        {8'h00, 16'd10},    {8'h01, 16'd20},  {8'h03, 16'd80},  {8'h08, 16'd20},
        {8'h13, 16'd240},   {8'h5A, 16'd480}, {8'h10, 16'd30},  {8'h7F, 16'd20480}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // Return at the negedge where a falling SCL edge is first seen.
    task automatic wait_fall();
        logic prev = scl_out;
        for (int k = 0; k < 50000; k++) begin
            @(negedge clk);
            if (prev && !scl_out) return;
            prev = scl_out;
        end
    endtask

    task automatic wait_rise();
        logic prev = scl_out;
        for (int k = 0; k < 50000; k++) begin
            @(negedge clk);
            if (!prev && scl_out) return;
            prev = scl_out;
        end
    endtask

    // Called at a fall; measures one period up to the next fall.
    task automatic measure(output int per, output int hi, output int chg_at,
                           output int smp_at, output int ticks);
        logic prev = scl_out;
        per = 0; hi = 0; chg_at = -1; smp_at = -1; ticks = 0;
        for (int c = 1; c < 50000; c++) begin
            @(negedge clk);
            if (phase_tick) ticks++;
            if (sda_change) chg_at = c;
            if (sda_sample) smp_at = c;
            if (scl_out) hi++;
            if (prev && !scl_out) begin
                per = c;
                return;
            end
            prev = scl_out;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int per, hi, chg_at, smp_at, ticks, c;
        logic prev;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(phase == 0, "R1 phase", phase, 0);
        chk(scl_out == 0, "R1 scl_out", scl_out, 0);
        chk(cfg_rdata == 8'h00, "R1 cfg_rdata", cfg_rdata, 0);
        chk({phase_tick, sda_change, sda_sample} == 3'b000, "R1 pulses",
            {phase_tick, sda_change, sda_sample}, 0);
        rst_n = 1'b1;

        // Table walk: R2 readback, R3 period, R4 duty, R5 ticks, R6 SDA points
        for (int v = 0; v < 8; v++) begin
            logic [7:0] cfg = VEC[v][23:16];
            int exp_per = int'(VEC[v][15:0]);
            int pl = exp_per / 10;
            wr(cfg);
            chk(cfg_rdata == (cfg & 8'h7F), "R2 readback", cfg_rdata, cfg & 8'h7F);
            wait_fall();
            measure(per, hi, chg_at, smp_at, ticks);
            chk(per == exp_per, "R3 period", per, exp_per);
            chk(hi == exp_per / 2, "R4 high time", hi, exp_per / 2);
            chk(ticks == 10, "R5 ticks per period", ticks, 10);
            chk(chg_at == 2 * pl, "R6 sda_change offset", chg_at, 2 * pl);
            chk(smp_at == 7 * pl, "R6 sda_sample offset", smp_at, 7 * pl);
        end

        // R2: bit 7 reads 0 and leaves timing at N=0, M=0
        wr(8'h80);
        chk(cfg_rdata == 8'h00, "R2 bit7 readback", cfg_rdata, 0);
        wait_fall();
        measure(per, hi, chg_at, smp_at, ticks);
        chk(per == 10, "R2 bit7 no effect on period", per, 10);

        // R10: phase order 0..9 then 0 (N=0, M=0, one clock per phase)
        wait_fall();
        begin
            bit seq_ok = 1'b1;
            int bad = 0;
            for (int k = 1; k <= 10; k++) begin
                @(negedge clk);
                if (phase != 4'(k % 10)) begin
                    seq_ok = 1'b0;
                    bad = phase;
                end
            end
            chk(seq_ok, "R10 phase sequence", bad, 0);
        end

        // R8: stretch 7 clocks from the rising edge -> high time 12
        wait_rise();
        hold = 1'b1;
        c = 0;
        prev = scl_out;
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk);
            c++;
            if (c == 7) begin
                chk(phase == 5, "R8 phase held while stretched", phase, 5);
                chk(scl_out == 1, "R8 scl released while stretched", scl_out, 1);
                hold = 1'b0;
            end
            if (prev && !scl_out) break;
            prev = scl_out;
        end
        chk(c == 12, "R8 stretched high time", c, 12);

        // R9: low readback in the low half is ignored
        hold = 1'b1;
        c = 0;
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk);
            c++;
            if (scl_out) break;
        end
        hold = 1'b0;
        chk(c == 5, "R9 low half unaffected", c, 5);

        // R7: write in mid period; the old setting finishes the period
        wr(8'h08);
        wait_fall();
        wait_fall();
        repeat (6) @(negedge clk);
        wr(8'h10);
        c = 7;
        prev = scl_out;
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk);
            c++;
            if (prev && !scl_out) break;
            prev = scl_out;
        end
        chk(c == 20, "R7 current period keeps old setting", c, 20);
        measure(per, hi, chg_at, smp_at, ticks);
        chk(per == 30, "R7 next period uses new setting", per, 30);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule